// File: doc/BRIEF.md
# Dual-Lane Latch/Register Bus Transceiver

This block moves data between two ports, A and B, over two independent lanes of 18 bits each. Each lane has two directions, A to B and B to A. Each direction holds one storage element and has its own latch-enable, transfer-clock and output-enable controls. A direction's storage element works in one of three ways. It passes its input straight through while the latch enable is high. It holds a stored word while the latch enable is low. It captures a new word when the transfer clock falls while the latch enable is low.

Each port appears as separate input, output and output-enable signals, so a pad ring above the block can build tri-state drivers. The output enables have opposite polarity in the two directions: the A-to-B enable is active high, and the B-to-A enable is active low. All controls are sampled in one system-clock domain. A falling transfer clock is therefore seen as a sampled change from 1 to 0. The reset is asynchronous and active low. Its release is synchronised inside the block, and it clears every storage element to zero.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While a direction's latch enable is 1, its output data equals its input data in the same cycle.
- R2: When the latch enable goes from 1 to 0, the output holds the input value of the last cycle in which the latch enable was 1. This holds even if the transfer clock is already 0.
- R3: While the latch enable is 0 and no capture takes place, the output data does not change from one cycle to the next.
- R4: With the latch enable at 0, a cycle in which the transfer clock is sampled as 0 after being 1 in the previous cycle captures the input. The captured word appears on the output from the next cycle on.
- R5: A transfer clock going from 0 to 1 while the latch enable is 0 captures nothing.
- R6: The B-side output-enable flag of a lane equals that lane's A-to-B enable pin (1 means B drives).
- R7: The A-side output-enable flag of a lane is the inverse of that lane's B-to-A enable pin (pin 0 means A drives).
- R8: The B-to-A direction behaves like the A-to-B direction, using its own controls. Each lane uses only its own controls and data, so one lane's inputs never change the other lane's outputs.
- R9: Asserting reset clears every stored word to zero at once, and the output-enable flags keep following their pins during reset. A transfer clock that is already 0 when reset is released causes no capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every control is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_in | input | 36 | Data arriving on port A, lane l in bits [18l+17:18l] |
| a_out | output | 36 | Data for port A to drive (B-to-A path) |
| a_oe | output | 2 | Per-lane flag, 1 when port A should drive |
| b_in | input | 36 | Data arriving on port B, same lane packing |
| b_out | output | 36 | Data for port B to drive (A-to-B path) |
| b_oe | output | 2 | Per-lane flag, 1 when port B should drive |
| ab_le | input | 2 | Per-lane A-to-B latch enable |
| ab_ck | input | 2 | Per-lane A-to-B transfer clock (sampled) |
| ab_oe | input | 2 | Per-lane A-to-B output enable, active high |
| ba_le | input | 2 | Per-lane B-to-A latch enable |
| ba_ck | input | 2 | Per-lane B-to-A transfer clock (sampled) |
| ba_oe_n | input | 2 | Per-lane B-to-A output enable, active low |

## Verification
The assertions assume that the latch-enable and transfer-clock inputs are steady and known at each rising system edge. They also assume that a transfer-clock fall counts only as a change between two consecutive samples. The stimulus meets this by changing every input only at the falling system edge. It holds the latch enables and transfer clocks at 0 while reset is applied and for a few cycles after release. This keeps the synchronised release from meeting a pending capture. Random transfer-clock toggles are spread out, so that hold and capture cycles both occur often.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    XM_HOLD = 2'd0,
    XM_PASS = 2'd1,
    XM_CAPT = 2'd2
  } xfer_mode_e;

  // Latch enable wins over a clock fall; a fall only counts with the latch closed.
  function automatic xfer_mode_e pick_mode(input logic le, input logic fall);
    if (le)        return XM_PASS;
    else if (fall) return XM_CAPT;
    else           return XM_HOLD;
  endfunction

endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ck_i,
  output logic fall_o
);

  logic ck_q;
  logic ck_d;

  always_comb begin
    ck_d = ck_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ck_q <= 1'b0;
    else         ck_q <= ck_d;
  end

  assign fall_o = ck_q & ~ck_i;

endmodule

// File: rtl/xcvr_dir_store.sv
module xcvr_dir_store #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic             ck_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  import xcvr_pkg::*;

  logic             fall;
  xfer_mode_e       mode;
  logic             load_en;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;

  xcvr_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ck_i   (ck_i),
    .fall_o (fall)
  );

  always_comb begin
    mode    = pick_mode(le_i, fall);
    load_en = (mode != XM_HOLD);
    store_d = load_en ? din_i : store_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) store_q <= '0;
    else         store_q <= store_d;
  end

  assign dout_o = (mode == XM_PASS) ? din_i : store_q;

  // R2
  last_pass_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(le_i) && !le_i) |-> (dout_o == $past(din_i)));

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !fall) |=> (le_i || $stable(dout_o)));

  // R4
  fall_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && fall) |=> (le_i || (dout_o == $past(din_i))));

  // R5
  change_needs_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $past(!le_i) && !$stable(dout_o)) |-> $past(fall));

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_in_i,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic [WIDTH-1:0] b_out_o,
  output logic             a_oe_o,
  output logic             b_oe_o,
  input  logic             ab_le_i,
  input  logic             ab_ck_i,
  input  logic             ab_oe_i,
  input  logic             ba_le_i,
  input  logic             ba_ck_i,
  input  logic             ba_oe_ni
);

  xcvr_dir_store #(.WIDTH(WIDTH)) u_ab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (ab_le_i),
    .ck_i   (ab_ck_i),
    .din_i  (a_in_i),
    .dout_o (b_out_o)
  );

  xcvr_dir_store #(.WIDTH(WIDTH)) u_ba (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (ba_le_i),
    .ck_i   (ba_ck_i),
    .din_i  (b_in_i),
    .dout_o (a_out_o)
  );

  always_comb begin
    b_oe_o = ab_oe_i;
    a_oe_o = ~ba_oe_ni;
  end

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] a_in,
  output logic [LANES*LANE_W-1:0] a_out,
  output logic [LANES-1:0]        a_oe,
  input  logic [LANES*LANE_W-1:0] b_in,
  output logic [LANES*LANE_W-1:0] b_out,
  output logic [LANES-1:0]        b_oe,
  input  logic [LANES-1:0]        ab_le,
  input  logic [LANES-1:0]        ab_ck,
  input  logic [LANES-1:0]        ab_oe,
  input  logic [LANES-1:0]        ba_le,
  input  logic [LANES-1:0]        ba_ck,
  input  logic [LANES-1:0]        ba_oe_n
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic [SYNC_STAGES-1:0] rst_pipe_d;
  logic                   rst_sync_n;

  always_comb begin
    rst_pipe_d = {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_lane #(.WIDTH(LANE_W)) u_lane (
      .clk_i    (clk),
      .rst_ni   (rst_sync_n),
      .a_in_i   (a_in[l*LANE_W +: LANE_W]),
      .b_in_i   (b_in[l*LANE_W +: LANE_W]),
      .a_out_o  (a_out[l*LANE_W +: LANE_W]),
      .b_out_o  (b_out[l*LANE_W +: LANE_W]),
      .a_oe_o   (a_oe[l]),
      .b_oe_o   (b_oe[l]),
      .ab_le_i  (ab_le[l]),
      .ab_ck_i  (ab_ck[l]),
      .ab_oe_i  (ab_oe[l]),
      .ba_le_i  (ba_le[l]),
      .ba_ck_i  (ba_ck[l]),
      .ba_oe_ni (ba_oe_n[l])
    );

    // R1
    ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ab_le[l] |-> (b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W]));

    // R8
    ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ba_le[l] |-> (a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W]));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
      (!rst_sync_n && !ab_le[l]) |-> (b_out[l*LANE_W +: LANE_W] == '0));
  end

endmodule

// File: tb/dual_bus_xcvr_bench.sv
module dual_bus_xcvr_bench;
  localparam int PERIOD = 10;
  localparam int L = 2;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic [L*W-1:0] a_in, b_in, a_out, b_out;
  logic [L-1:0] a_oe, b_oe, ab_le, ab_ck, ab_oe, ba_le, ba_ck, ba_oe_n;

  int n_checks = 0;
  int n_fail = 0;

  logic [W-1:0] m_ab [L];
  logic [W-1:0] m_ba [L];
  logic         p_ab [L];
  logic         p_ba [L];

  always #(PERIOD/2) clk = ~clk;

  dual_bus_xcvr u_dual_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_le(ab_le), .ab_ck(ab_ck),
    .ab_oe(ab_oe), .ba_le(ba_le), .ba_ck(ba_ck), .ba_oe_n(ba_oe_n)
  );

  // {le, ck, data in, expected B output} for lane 0, A to B
  localparam logic [37:0] TBL [14] = '{
    {1'b1, 1'b0, 18'h00011, 18'h00011},  // R1
    {1'b1, 1'b0, 18'h2A5A5, 18'h2A5A5},  // R1
    {1'b0, 1'b0, 18'h3FFFF, 18'h2A5A5},  // R2 drop while ck low
    {1'b0, 1'b1, 18'h12345, 18'h2A5A5},  // R5 rising ck
    {1'b0, 1'b1, 18'h0F0F0, 18'h2A5A5},  // R3
    {1'b0, 1'b0, 18'h15555, 18'h2A5A5},  // R4 fall seen
    {1'b0, 1'b0, 18'h00000, 18'h15555},  // R4 captured
    {1'b0, 1'b0, 18'h3C3C3, 18'h15555},  // R3
    {1'b0, 1'b1, 18'h11111, 18'h15555},  // R5
    {1'b1, 1'b1, 18'h22222, 18'h22222},  // R1
    {1'b0, 1'b1, 18'h33333, 18'h22222},  // R2 drop while ck high
    {1'b0, 1'b0, 18'h00ABC, 18'h22222},  // R4 fall seen
    {1'b0, 1'b0, 18'h3FFFF, 18'h00ABC},  // R4 captured
    {1'b1, 1'b0, 18'h00001, 18'h00001}   // R1
  };

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int l = 0; l < L; l++) begin
      m_ab[l] = '0; m_ba[l] = '0; p_ab[l] = 1'b0; p_ba[l] = 1'b0;
    end
  endtask

  // Compare all outputs with the model, then advance the model over one edge.
  task automatic cycle_check();
    logic [W-1:0] eb, ea;
    #1;
    for (int l = 0; l < L; l++) begin
      eb = ab_le[l] ? a_in[l*W +: W] : m_ab[l];
      ea = ba_le[l] ? b_in[l*W +: W] : m_ba[l];
      check(b_out[l*W +: W] == eb, "R1/R4 model A->B (R8 lane split)", b_out[l*W +: W], eb);
      check(a_out[l*W +: W] == ea, "R8 model B->A", a_out[l*W +: W], ea);
      check(b_oe[l] == ab_oe[l], "R6 B enable", W'(b_oe[l]), W'(ab_oe[l]));
      check(a_oe[l] == !ba_oe_n[l], "R7 A enable", W'(a_oe[l]), W'(!ba_oe_n[l]));
    end
    @(posedge clk);
    for (int l = 0; l < L; l++) begin
      if (!rst_n) begin
        m_ab[l] = '0; m_ba[l] = '0; p_ab[l] = 1'b0; p_ba[l] = 1'b0;
      end else begin
        if (ab_le[l] || (p_ab[l] && !ab_ck[l])) m_ab[l] = a_in[l*W +: W];
        if (ba_le[l] || (p_ba[l] && !ba_ck[l])) m_ba[l] = b_in[l*W +: W];
        p_ab[l] = ab_ck[l];
        p_ba[l] = ba_ck[l];
      end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(PERIOD*20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0; ab_le = '0; ab_ck = '0; ba_le = '0; ba_ck = '0;
    ab_oe = 2'b01; ba_oe_n = 2'b10;
    model_clear();
    // R9: enables follow pins while in reset, storage reads zero
    @(negedge clk);
    a_in = {2{18'h3FFFF}}; b_in = {2{18'h2AAAA}};
    cycle_check();
    @(negedge clk);
    ab_oe = 2'b10; ba_oe_n = 2'b01;
    cycle_check();
    check(b_out == '0, "R9 reset clear", b_out[W-1:0], '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cycle_check();
      @(negedge clk);
    end
    check(b_out == '0 && a_out == '0, "R9 no capture on release", b_out[W-1:0], '0);

    // Table walk: lane 0 A->B; lane 1 kept closed with zero store
    ab_oe = 2'b11; ba_oe_n = 2'b00; a_in = '0; b_in = '0;
    for (int i = 0; i < 14; i++) begin
      ab_le[0] = TBL[i][37];
      ab_ck[0] = TBL[i][36];
      a_in[W-1:0] = TBL[i][35:18];
      a_in[2*W-1:W] = TBL[i][35:18] ^ 18'h3FFFF;
      #1;
      check(b_out[W-1:0] == TBL[i][17:0], "R1 R2 R3 R4 R5 table row",
            b_out[W-1:0], TBL[i][17:0]);
      check(b_out[2*W-1:W] == '0, "R8 lane 1 untouched", b_out[2*W-1:W], '0);
      cycle_check();
      @(negedge clk);
    end

    // Random sequences over both lanes and both directions
    for (int i = 0; i < 600; i++) begin
      a_in = {$urandom, $urandom};
      b_in = {$urandom, $urandom};
      for (int l = 0; l < L; l++) begin
        ab_le[l] = ($urandom_range(0, 4) == 0);
        ba_le[l] = ($urandom_range(0, 4) == 0);
        if ($urandom_range(0, 2) == 0) ab_ck[l] = ~ab_ck[l];
        if ($urandom_range(0, 2) == 0) ba_ck[l] = ~ba_ck[l];
      end
      ab_oe = 2'($urandom);
      ba_oe_n = 2'($urandom);
      cycle_check();
      @(negedge clk);
    end

    // R8 directed: B->A capture on lane 1 only
    ab_le = '0; ab_ck = '0; ba_le = 2'b00; ba_ck = 2'b10;
    cycle_check();
    @(negedge clk);
    ba_ck = 2'b00; b_in = {18'h1BEEF, 18'h00F00};
    cycle_check();
    @(negedge clk);
    #1;
    check(a_out[2*W-1:W] == 18'h1BEEF, "R8 B->A lane 1 capture", a_out[2*W-1:W], 18'h1BEEF);

    // R9: asynchronous clear mid-run with latches closed
    ab_le = '0; ba_le = '0; ab_ck = '0; ba_ck = '0;
    rst_n = 1'b0;
    model_clear();
    #1;
    check(a_out == '0 && b_out == '0, "R9 async clear", a_out[2*W-1:W], '0);
    @(negedge clk);
    cycle_check();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cycle_check();
      @(negedge clk);
    end
    finish_run();
  end

endmodule